// File: doc/BRIEF.md
# Multi-Channel Third-Order Sinc Decimator with Synchronous Restart

This block turns several 1-bit sigma-delta bit streams into 16-bit decimated samples. Each channel runs a third-order cascaded integrator-comb filter. The integrators run at the bit rate, and the comb runs once per group of OSR accepted bits. The bit streams arrive as a data bit plus a one-cycle strobe in the system clock domain. The OSR is set at run time, and a programmable right shift picks which 16 bits of the wide result are delivered.

A shared `restart` pulse, typically driven by a control-timer compare event, clears every channel's integrators, comb history and group counters in the same cycle. This lets the conversion window be placed at a known point of the timer period. The first two decimated outputs after a restart (or reset) come from a filter that has not yet seen a full window, so they are dropped. The third output, which spans three full groups of bits, is the first one delivered.

Each channel raises a sticky acknowledge flag when it delivers a sample. Software clears the flags by writing ones to `ack_clr`, either one channel at a time or all at once.

Top module: `sinc3_decim`

## Requirements
- R1: While and after synchronous reset, `data_vld`, `ack_flag` and `data_out` are all zero.
- R2: A channel delivers at most one sample per group of OSR accepted strobes (OSR = `osr_m1`+1). `data_vld` is a single-cycle pulse in the cycle after the strobe that completes a group.
- R3: After reset or restart, the first two completed groups of a channel produce no `data_vld` pulse. Every later group produces one.
- R4: The delivered value is (S >> `shift`) truncated to 16 bits. S is the sum over the latest accepted bits (bit value 0 or 1) weighted by the sinc3 taps h[j], for j from 0 to 3·OSR−3. The taps are the threefold convolution of a length-OSR boxcar, with j=0 the bit that completes the group. Bits before the last restart count as zero.
- R5: The accumulators are 3·log2(OSR_MAX)+1 bits wide and wrap. A stream of all ones gives OSR³ exactly; for example OSR 128 with shift 6 gives 32768.
- R6: `restart` clears the filter state of all channels. A strobe in the same cycle as `restart` is discarded. No `data_vld` follows a restart in the next cycle. `restart` leaves `ack_flag` unchanged.
- R7: `ack_flag[i]` is set in the same cycle as `data_vld[i]` and holds until a cycle with `ack_clr[i]`=1. Clear bits act on their own channel only, and any set of channels can be cleared in one write.
- R8: If a new sample and a clear of the same channel come in the same cycle, the flag ends up set.
- R9: Channels given identical strobes and bits deliver equal values with `data_vld` in the same cycle.
- R10: The shift amount applies to every channel's output, and a non-power-of-two OSR is supported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Shared restart pulse aligning all channels |
| osr_m1 | input | OSR_W | Oversampling ratio minus one |
| shift | input | SH_W | Right shift applied to the wide result |
| bit_en | input | NCH | Per-channel strobe: a modulator bit is present |
| bit_in | input | NCH | Per-channel modulator bit |
| ack_clr | input | NCH | Write-1 clear of the acknowledge flags |
| data_out | output | NCH·16 | Decimated samples, channel i in bits [16i+15:16i] |
| data_vld | output | NCH | Sample-delivered pulse per channel |
| ack_flag | output | NCH | Sticky acknowledge flag per channel |

## Verification
The properties assume that `osr_m1` is at least 1, so strobes that complete groups are at least two strobes apart and each `data_vld` stays a single pulse. They also assume that `osr_m1` and `shift` change only in the cycle of a restart. The stimulus changes both settings only together with a restart pulse. It uses ratios of 5, 8 and 128, so the largest sum stays below the accumulator range and never wraps.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
  // Accumulator width that holds OSR^3 without loss for the largest OSR.
  function automatic int acc_w(input int osr_max);
    return 3 * $clog2(osr_max) + 1;
  endfunction
endpackage

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
  parameter int ACC_W = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             bit_en,
  input  logic             bit_in,
  output logic [ACC_W-1:0] acc_nx
);
  logic [ACC_W-1:0] i1, i2, i3;
  logic [ACC_W-1:0] n1, n2, n3;

  // Chained update: the third sum already includes the current bit.
  always_comb begin
    n1     = i1 + ACC_W'(bit_in);
    n2     = i2 + n1;
    n3     = i3 + n2;
    acc_nx = n3;
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      i1 <= '0;
      i2 <= '0;
      i3 <= '0;
    end else if (bit_en) begin
      i1 <= n1;
      i2 <= n2;
      i3 <= n3;
    end
  end
endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
  parameter int ACC_W = 25,
  parameter int OUT_W = 16,
  parameter int SH_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             take,
  input  logic             keep,
  input  logic [ACC_W-1:0] samp,
  input  logic [SH_W-1:0]  shamt,
  output logic [OUT_W-1:0] dout,
  output logic             dvld
);
  logic [ACC_W-1:0] s0, s1, s2;
  logic [ACC_W-1:0] d1, d2, d3;

  always_comb begin
    d1 = samp - s0;
    d2 = d1 - s1;
    d3 = d2 - s2;
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      s0   <= '0;
      s1   <= '0;
      s2   <= '0;
      dvld <= 1'b0;
      if (rst) dout <= '0;
    end else begin
      dvld <= take && keep;
      if (take) begin
        s0 <= samp;
        s1 <= d1;
        s2 <= d2;
        if (keep) dout <= OUT_W'(d3 >> shamt);
      end
    end
  end
endmodule

// File: rtl/sinc3_chan.sv
module sinc3_chan #(
  parameter int ACC_W = 25,
  parameter int OSR_W = 8,
  parameter int OUT_W = 16,
  parameter int SH_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             bit_en,
  input  logic             bit_in,
  input  logic [OSR_W-1:0] osr_m1,
  input  logic [SH_W-1:0]  shamt,
  output logic             fire,
  output logic [OUT_W-1:0] dout,
  output logic             dvld
);
  localparam int SKIP = 2;

  logic [OSR_W-1:0] phase;
  logic [1:0]       nout;
  logic             take, keep;
  logic [ACC_W-1:0] acc_nx;

  assign take = bit_en && !restart && (phase == osr_m1);
  assign keep = (nout == 2'(SKIP));
  assign fire = take && keep;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      phase <= '0;
      nout  <= '0;
    end else if (bit_en) begin
      if (phase == osr_m1) begin
        phase <= '0;
        if (!keep) nout <= nout + 2'd1;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  sinc3_integ #(.ACC_W(ACC_W)) u_integ (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .bit_en  (bit_en),
    .bit_in  (bit_in),
    .acc_nx  (acc_nx)
  );

  sinc3_comb #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SH_W(SH_W)) u_comb (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .take    (take),
    .keep    (keep),
    .samp    (acc_nx),
    .shamt   (shamt),
    .dout    (dout),
    .dvld    (dvld)
  );
endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim #(
  parameter int NCH     = 3,
  parameter int OSR_MAX = 256,
  parameter int OUT_W   = 16,
  localparam int OSR_W  = $clog2(OSR_MAX),
  localparam int ACC_W  = sinc3_pkg::acc_w(OSR_MAX),
  localparam int SH_W   = $clog2(ACC_W)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 restart,
  input  logic [OSR_W-1:0]     osr_m1,
  input  logic [SH_W-1:0]      shift,
  input  logic [NCH-1:0]       bit_en,
  input  logic [NCH-1:0]       bit_in,
  input  logic [NCH-1:0]       ack_clr,
  output logic [NCH*OUT_W-1:0] data_out,
  output logic [NCH-1:0]       data_vld,
  output logic [NCH-1:0]       ack_flag
);
  logic [NCH-1:0] fire;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    sinc3_chan #(.ACC_W(ACC_W), .OSR_W(OSR_W), .OUT_W(OUT_W), .SH_W(SH_W)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .restart (restart),
      .bit_en  (bit_en[ch]),
      .bit_in  (bit_in[ch]),
      .osr_m1  (osr_m1),
      .shamt   (shift),
      .fire    (fire[ch]),
      .dout    (data_out[ch*OUT_W +: OUT_W]),
      .dvld    (data_vld[ch])
    );
  end

  // Sticky flags, write-1-to-clear; a new sample overrides a clear.
  always_ff @(posedge clk) begin
    if (rst) ack_flag <= '0;
    else     ack_flag <= (ack_flag & ~ack_clr) | fire;
  end
endmodule

// File: rtl/sinc3_decim_chk.sv
module sinc3_decim_chk #(
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           restart,
  input logic [NCH-1:0] ack_clr,
  input logic [NCH-1:0] data_vld,
  input logic [NCH-1:0] ack_flag
);
  for (genvar i = 0; i < NCH; i++) begin : g_p
    assert_vld_pulse_R2: assert property (@(posedge clk) disable iff (rst)
      data_vld[i] |=> !data_vld[i]);
    assert_restart_quiet_R6: assert property (@(posedge clk) disable iff (rst)
      restart |=> !data_vld[i]);
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
      data_vld[i] |-> ack_flag[i]);
    assert_flag_rise_R7: assert property (@(posedge clk) disable iff (rst)
      $rose(ack_flag[i]) |-> data_vld[i]);
    assert_flag_fall_R7: assert property (@(posedge clk) disable iff (rst)
      $fell(ack_flag[i]) |-> $past(ack_clr[i]));
    assert_flag_hold_R7: assert property (@(posedge clk) disable iff (rst)
      (ack_flag[i] && !ack_clr[i]) |=> ack_flag[i]);
  end
endmodule

bind sinc3_decim sinc3_decim_chk #(.NCH(NCH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .restart  (restart),
  .ack_clr  (ack_clr),
  .data_vld (data_vld),
  .ack_flag (ack_flag)
);

// File: tb/sinc3_decim_tb.sv
module sinc3_decim_tb;
  localparam int NCH = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        restart = 1'b0;
  logic [7:0]  osr_m1 = 8'd7;
  logic [4:0]  shift = 5'd0;
  logic [2:0]  bit_en = '0, bit_in = '0, ack_clr = '0;
  logic [47:0] data_out;
  logic [2:0]  data_vld, ack_flag;

  always #2.5 clk = ~clk;

  sinc3_decim u_dut (
    .clk(clk), .rst(rst), .restart(restart), .osr_m1(osr_m1), .shift(shift),
    .bit_en(bit_en), .bit_in(bit_in), .ack_clr(ack_clr),
    .data_out(data_out), .data_vld(data_vld), .ack_flag(ack_flag)
  );

  int nchk = 0, nfail = 0;
  int osr = 8, sh = 0;
  bit hb [NCH][1024];
  int nb [NCH], gc [NCH], oc [NCH], vcnt [NCH];
  longint lastv [NCH];
  longint exp_q [$];
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint htap(input int j, input int r);
    int m;
    if (j < r) return longint'((j + 1) * (j + 2) / 2);
    if (j < 2 * r) return longint'((j + 1) * (j + 2) / 2 - 3 * (j - r + 1) * (j - r + 2) / 2);
    m = 3 * r - 3 - j;
    return longint'((m + 1) * (m + 2) / 2);
  endfunction

  function automatic longint fir(input int ch);
    longint s = 0;
    for (int j = 0; j <= 3 * osr - 3; j++)
      if (j < nb[ch] && hb[ch][(nb[ch] - 1 - j) & 1023]) s += htap(j, osr);
    return s;
  endfunction

  function automatic bit nextbit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  // Driver: applies one cycle of stimulus and updates the reference model.
  task automatic step(input logic [2:0] e, input logic [2:0] d, input logic rs, input logic [2:0] c);
    @(negedge clk);
    bit_en = e; bit_in = d; restart = rs; ack_clr = c;
    for (int ch = 0; ch < NCH; ch++) begin
      if (rs) begin
        nb[ch] = 0; gc[ch] = 0; oc[ch] = 0;
      end else if (e[ch]) begin
        hb[ch][nb[ch] & 1023] = d[ch];
        nb[ch]++;
        gc[ch]++;
        if (gc[ch] == osr) begin
          gc[ch] = 0;
          if (oc[ch] >= 2) exp_q.push_back(longint'(ch) * 65536 + ((fir(ch) >> sh) & 64'hFFFF));
          else oc[ch]++;
        end
      end
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(3'b000, 3'b000, 1'b0, 3'b000);
  endtask

  task automatic set_cfg(input int r, input int s);
    @(negedge clk);
    osr = r; sh = s;
    osr_m1 = 8'(r - 1); shift = 5'(s);
    step(3'b000, 3'b000, 1'b1, 3'b000);
  endtask

  // Monitor: pops expected samples as the design delivers them.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        for (int ch = 0; ch < NCH; ch++) begin
          if (data_vld[ch]) begin
            vcnt[ch]++;
            lastv[ch] = longint'(data_out[ch*16 +: 16]);
            if (exp_q.size() == 0) begin
              chk(1'b0, "R4 unexpected sample", lastv[ch], -1);
            end else begin
              longint e;
              e = exp_q.pop_front();
              chk(e == longint'(ch) * 65536 + lastv[ch], "R4 R10 sample value",
                  longint'(ch) * 65536 + lastv[ch], e);
            end
          end
        end
      end
    end
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int base [NCH];
    logic [2:0] fl;
    for (int ch = 0; ch < NCH; ch++) begin
      nb[ch] = 0; gc[ch] = 0; oc[ch] = 0; vcnt[ch] = 0; lastv[ch] = 0;
    end
    repeat (3) @(negedge clk);
    chk(data_vld == 0 && ack_flag == 0 && data_out == 0, "R1 reset state", longint'(data_out), 0);
    @(negedge clk); rst = 1'b0;

    // Identical random streams, OSR 8, shift 0.
    set_cfg(8, 0);
    for (int k = 0; k < 96; k++) begin
      logic b;
      b = nextbit();
      step(3'b111, {b, b, b}, 1'b0, 3'b000);
    end
    idle(3);
    for (int ch = 0; ch < NCH; ch++)
      chk(vcnt[ch] == 10, "R2 R3 sample count 12 groups", vcnt[ch], 10);
    chk(ack_flag == 3'b111, "R9 flags together", ack_flag, 7);
    chk(data_out[15:0] == data_out[31:16] && data_out[15:0] == data_out[47:32],
        "R9 equal values", data_out[31:16], data_out[15:0]);

    // Flag clearing.
    step(3'b000, 3'b000, 1'b0, 3'b010); idle(1);
    chk(ack_flag == 3'b101, "R7 single clear", ack_flag, 5);
    step(3'b000, 3'b000, 1'b0, 3'b101); idle(1);
    chk(ack_flag == 3'b000, "R7 clear together", ack_flag, 0);

    // Distinct, irregular streams, OSR 5, shift 2.
    set_cfg(5, 2);
    for (int k = 0; k < 240; k++) begin
      logic b;
      logic [2:0] e;
      b = nextbit();
      e = {nextbit(), k[0], 1'b1};
      step(e, {k[1], 1'b1, b}, 1'b0, 3'b000);
    end
    idle(3);
    chk(vcnt[0] == 10 + 46, "R3 R10 count OSR 5", vcnt[0], 56);

    // Set beats clear in the same cycle.
    step(3'b000, 3'b000, 1'b0, 3'b111); idle(1);
    while (!(gc[0] == osr - 1 && oc[0] >= 2)) step(3'b001, 3'b001, 1'b0, 3'b000);
    step(3'b001, 3'b001, 1'b0, 3'b001); idle(1);
    chk(ack_flag[0] == 1'b1, "R8 set wins over clear", ack_flag[0], 1);

    // Restart: flags kept, coincident bit dropped, mid-group restart.
    idle(2);
    fl = ack_flag;
    @(negedge clk);
    osr = 8; sh = 0; osr_m1 = 8'd7; shift = 5'd0;
    step(3'b111, 3'b111, 1'b1, 3'b000); idle(1);
    chk(ack_flag == fl, "R6 flags kept across restart", ack_flag, fl);
    for (int k = 0; k < 13; k++) step(3'b111, 3'b111, 1'b0, 3'b000);
    step(3'b111, 3'b111, 1'b1, 3'b000);
    for (int ch = 0; ch < NCH; ch++) base[ch] = vcnt[ch];
    for (int k = 0; k < 40; k++) step(3'b111, 3'b111, 1'b0, 3'b000);
    idle(3);
    for (int ch = 0; ch < NCH; ch++)
      chk(vcnt[ch] - base[ch] == 3, "R6 count after mid-group restart", vcnt[ch] - base[ch], 3);
    chk(lastv[0] == 512, "R5 all ones OSR 8", lastv[0], 512);

    // Full scale at OSR 128, shift 6.
    set_cfg(128, 6);
    for (int ch = 0; ch < NCH; ch++) base[ch] = vcnt[ch];
    for (int k = 0; k < 512; k++) step(3'b111, 3'b111, 1'b0, 3'b000);
    idle(3);
    for (int ch = 0; ch < NCH; ch++) begin
      chk(vcnt[ch] - base[ch] == 2, "R3 count OSR 128", vcnt[ch] - base[ch], 2);
      chk(lastv[ch] == 32768, "R5 all ones OSR 128", lastv[ch], 32768);
    end

    chk(exp_q.size() == 0, "R2 no missing samples", exp_q.size(), 0);
    report();
  end
endmodule